// File: doc/BRIEF.md
# Integer ALU with Zero and Carry Flags

This block is the integer execution unit of a 32-bit processor datapath. On a cycle where the caller presents a valid operation, it combines two register operands and registers three things at the same clock edge: a result, a write-enable for the register file, and an updated flags word. It supports add, reversed subtract, compare, one-bit logical shifts, increment and decrement. The unit keeps the flags word itself. Only bit 0 (zero) and bit 1 (carry) change on an operation, and the caller can load the whole word when no operation is issued.

The caller reads the source registers, drives them on `src_a` and `src_b`, and writes `res` back when `wr_en` is high. An operation code the unit does not support leaves the result and flags untouched and raises `bad_op` for one cycle.

Top module: `flag_alu`

## Requirements
- R1: While `rst_n` is low, `res`, `flags`, `wr_en` and `bad_op` are all zero.
- R2: Operation codes are add=0, sub=1, cmp=2, shl=3, shr=4, inc=5 and dec=6. Add yields `src_a + src_b` modulo 2^32, and carry (flags bit 1) takes the carry out of bit 31.
- R3: Sub and cmp both compute `src_b - src_a`, and carry is set when a borrow occurs (`src_b < src_a`). Cmp updates the flags but leaves `res` unchanged and `wr_en` low.
- R4: Shl yields `src_a` shifted left by one with carry taken from `src_a` bit 31. Shr is a logical right shift by one with carry taken from `src_a` bit 0.
- R5: Inc yields `src_a + 1`, with carry set when `src_a` is all ones. Dec yields `src_a - 1`, with carry set when `src_a` is zero.
- R6: For every supported operation, including cmp, flags bit 0 is set exactly when the 32-bit computed value is zero.
- R7: Operations never change flags bits above bit 1.
- R8: One clock after a valid operation other than cmp, `wr_en` is high for one cycle, and `res` and `flags` both show the new values from that same edge.
- R9: Code 7 raises `bad_op` for one cycle after issue. It keeps `wr_en` low and leaves `res` and `flags` unchanged.
- R10: A cycle without `exec_en` (and without a flags load) drives `wr_en` and `bad_op` low and holds `res` and `flags`.
- R11: `flags_wr` loads `flags_din` into the whole flags word on the next edge when `exec_en` is low. It is ignored when `exec_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Operation valid this cycle |
| op_sel | input | 3 | Operation code |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| flags_wr | input | 1 | Load the flags word from `flags_din` |
| flags_din | input | 32 | Value for a flags load |
| res | output | 32 | Registered result |
| wr_en | output | 1 | Write-back enable for `res` |
| flags | output | 32 | Flags word (bit 0 zero, bit 1 carry) |
| bad_op | output | 1 | Unsupported operation code seen |

## Verification
Each operation is tried with operands at the carry boundaries, so that carry and no-carry outcomes are told apart:
- all-ones plus one, and zero minus one;
- subtract with the second operand above, equal to and below the first;
- shifts of values with the top and bottom bits set.

Equal-operand compares and results that wrap to zero separate the zero flag from the result register. Compare and the unsupported code show that write-back is suppressed and the result is held. A flags word preloaded with a patterned upper half shows that only the low two bits move. A stretch of random operands and codes, with idle cycles and loads mixed in, is then checked against a behavioural model on every clock.

// File: rtl/flag_alu.sv
module flag_alu #(
  parameter int W   = 32,
  parameter int FW  = 32,
  parameter int OPW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec_en,
  input  logic [OPW-1:0] op_sel,
  input  logic [W-1:0]  src_a,
  input  logic [W-1:0]  src_b,
  input  logic          flags_wr,
  input  logic [FW-1:0] flags_din,
  output logic [W-1:0]  res,
  output logic          wr_en,
  output logic [FW-1:0] flags,
  output logic          bad_op
);
  localparam logic [OPW-1:0] OP_ADD = OPW'(0);
  localparam logic [OPW-1:0] OP_SUB = OPW'(1);
  localparam logic [OPW-1:0] OP_CMP = OPW'(2);
  localparam logic [OPW-1:0] OP_SHL = OPW'(3);
  localparam logic [OPW-1:0] OP_SHR = OPW'(4);
  localparam logic [OPW-1:0] OP_INC = OPW'(5);
  localparam logic [OPW-1:0] OP_DEC = OPW'(6);

  logic [W-1:0] nxt;
  logic         cy;
  logic         known;
  logic         zero;

  always_comb begin
    known = 1'b1;
    nxt   = res;
    cy    = flags[1];
    case (op_sel)
      OP_ADD:         {cy, nxt} = {1'b0, src_a} + {1'b0, src_b};
      OP_SUB, OP_CMP: {cy, nxt} = {1'b0, src_b} - {1'b0, src_a};
      OP_SHL:         {cy, nxt} = {src_a, 1'b0};
      OP_SHR:         {nxt, cy} = {1'b0, src_a};
      OP_INC:         {cy, nxt} = {1'b0, src_a} + (W+1)'(1);
      OP_DEC:         {cy, nxt} = {1'b0, src_a} - (W+1)'(1);
      default:        known = 1'b0;
    endcase
  end

  assign zero = (nxt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res    <= '0;
      flags  <= '0;
      wr_en  <= 1'b0;
      bad_op <= 1'b0;
    end else begin
      wr_en  <= 1'b0;
      bad_op <= 1'b0;
      if (exec_en) begin
        if (known) begin
          flags <= {flags[FW-1:2], cy, zero};
          if (op_sel != OP_CMP) begin
            res   <= nxt;
            wr_en <= 1'b1;
          end
        end else begin
          bad_op <= 1'b1;
        end
      end else if (flags_wr) begin
        flags <= flags_din;
      end
    end
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W   = 32,
  parameter int FW  = 32,
  parameter int OPW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          exec_en,
  input logic [OPW-1:0] op_sel,
  input logic [W-1:0]  src_a,
  input logic [W-1:0]  src_b,
  input logic          flags_wr,
  input logic [W-1:0]  res,
  input logic          wr_en,
  input logic [FW-1:0] flags,
  input logic          bad_op
);
  // R2
  add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == OPW'(0) |=> res == W'($past(src_a) + $past(src_b)));

  // R3
  cmp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == OPW'(2) |=> !wr_en && res == $past(res));

  // R6
  zero_on_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> flags[0] == (res == '0));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en |=> flags[FW-1:2] == $past(flags[FW-1:2]));

  // R9
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && op_sel == OPW'(7) |=> bad_op && !wr_en && $stable(res) && $stable(flags));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en && !flags_wr |=> !wr_en && !bad_op && $stable(res) && $stable(flags));

  // R8
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && bad_op));
endmodule

bind flag_alu flag_alu_chk #(.W(W), .FW(FW), .OPW(OPW)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
  .src_a(src_a), .src_b(src_b), .flags_wr(flags_wr), .res(res),
  .wr_en(wr_en), .flags(flags), .bad_op(bad_op)
);

// File: tb/test_flag_alu.sv
`timescale 1ns/1ps
module test_flag_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec_en = 1'b0;
  logic [2:0]  op_sel = '0;
  logic [31:0] src_a = '0, src_b = '0;
  logic        flags_wr = 1'b0;
  logic [31:0] flags_din = '0;
  logic [31:0] res, flags;
  logic        wr_en, bad_op;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_res = '0, m_flags = '0;
  logic        m_we = 1'b0, m_bad = 1'b0;

  always #2.5 clk = ~clk;

  flag_alu i_flag_alu (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .op_sel(op_sel),
    .src_a(src_a), .src_b(src_b), .flags_wr(flags_wr), .flags_din(flags_din),
    .res(res), .wr_en(wr_en), .flags(flags), .bad_op(bad_op)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " res"},    res,    m_res);
    chk({tag, " flags"},  flags,  m_flags);
    chk({tag, " wr_en"},  {31'd0, wr_en},  {31'd0, m_we});
    chk({tag, " bad_op"}, {31'd0, bad_op}, {31'd0, m_bad});
  endtask

  task automatic step(input string tag, input bit en, input int op,
                      input longint a, input longint b,
                      input bit fw, input logic [31:0] fd);
    longint mask = 64'hFFFF_FFFF;
    longint r = 0;
    bit     c = 0;
    bit     ok = 1;
    @(negedge clk);
    exec_en = en; op_sel = 3'(op); src_a = 32'(a); src_b = 32'(b);
    flags_wr = fw; flags_din = fd;
    m_we = 0; m_bad = 0;
    if (en) begin
      case (op)
        0: begin r = (a + b) & mask; c = ((a + b) >> 32) != 0; end
        1, 2: begin r = (b - a) & mask; c = b < a; end
        3: begin r = (a * 2) & mask; c = a >= 64'h8000_0000; end
        4: begin r = a / 2; c = (a % 2) == 1; end
        5: begin r = (a + 1) & mask; c = a == mask; end
        6: begin r = (a - 1) & mask; c = a == 0; end
        default: ok = 0;
      endcase
      if (ok) begin
        m_flags[1] = c;
        m_flags[0] = (r == 0);
        if (op != 2) begin
          m_res = 32'(r);
          m_we = 1;
        end
      end else begin
        m_bad = 1;
      end
    end else if (fw) begin
      m_flags = fd;
    end
    @(posedge clk);
    #1;
    compare(tag);
  endtask

  initial begin
    #(5.0 * 50000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compare("R1 reset");
    @(negedge clk);
    rst_n = 1'b1;

    step("R2 add small",      1, 0, 5, 7, 0, 0);
    step("R2 add carry wrap", 1, 0, 64'hFFFF_FFFF, 1, 0, 0);
    step("R2 add big",        1, 0, 64'h8000_0000, 64'h8000_0001, 0, 0);
    step("R3 sub b>a",        1, 1, 3, 10, 0, 0);
    step("R3 sub borrow",     1, 1, 10, 3, 0, 0);
    step("R3 cmp equal",      1, 2, 42, 42, 0, 0);
    step("R3 cmp borrow",     1, 2, 9, 1, 0, 0);
    step("R4 shl top",        1, 3, 64'h8000_0001, 0, 0, 0);
    step("R4 shl no carry",   1, 3, 64'h4000_0000, 0, 0, 0);
    step("R4 shr low",        1, 4, 3, 0, 0, 0);
    step("R6 shr to zero",    1, 4, 1, 0, 0, 0);
    step("R5 inc wrap",       1, 5, 64'hFFFF_FFFF, 0, 0, 0);
    step("R5 inc plain",      1, 5, 7, 0, 0, 0);
    step("R5 dec zero",       1, 6, 0, 0, 0, 0);
    step("R5 dec plain",      1, 6, 5, 0, 0, 0);
    step("R9 bad code",       1, 7, 1, 2, 0, 0);
    step("R10 idle",          0, 0, 11, 22, 0, 0);
    step("R11 flags load",    0, 0, 0, 0, 1, 32'hA5A5_A5A4);
    step("R7 add keeps upper", 1, 0, 64'hFFFF_FFFF, 1, 0, 0);
    step("R7 sub keeps upper", 1, 1, 1, 5, 0, 0);
    step("R11 load ignored",  1, 5, 1, 0, 1, 32'h0000_0000);
    step("R8 inc after",      1, 5, 100, 0, 0, 0);
    step("R9 bad keeps",      1, 7, 0, 0, 0, 0);
    step("R10 idle again",    0, 6, 0, 0, 0, 0);

    for (int i = 0; i < 200; i++) begin
      int k = int'($urandom_range(0, 9));
      longint a = longint'($urandom);
      longint b = longint'($urandom);
      if (k == 8)
        step("R10 rnd idle", 0, 0, a, b, 0, 0);
      else if (k == 9)
        step("R11 rnd load", 0, 0, 0, 0, 1, $urandom);
      else
        step("R8 rnd op", 1, k, a, b, 0, 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule